// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose pad lines controlled through 32-bit register words. Each line works in one of three ways: as a plain input, as a plain output driven from an output latch, or as an interrupt source. An interrupt source can sense a level or an edge. A polarity bit picks high or rising against low or falling, and an optional both-edge bit makes any transition count. Pad inputs are brought into the clock domain by a flop synchroniser before any sensing.

Each interrupt line keeps one status bit. In edge mode the bit latches and stays set until software writes a one to the clear word. In level mode the bit tracks the input after polarity and cannot be cleared while the level holds. An enable mask gates the status bits, and one interrupt output rises whenever an enabled status bit is set. Enables are turned off by writing zeros to the mask word and turned on by writing ones to a separate unmask word. Software reaches the bank through a valid/ready request port that is always ready. A read answers one cycle after it is accepted.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero and `irq` is low.
- R2: `pad_oe` bit n is 1 only when direction bit n (word 0x04) is 1 and mode bit n (word 0x00) is 0. `pad_out` carries the output latch (word 0x08).
- R3: Reading word 0x0C returns the output latch bit for each line with an active output enable. For every other line it returns the synchronised pad, which lags the pad by at least two clock edges.
- R4: Level sensing (mode bit 1, word 0x24 bit 0): the status bit (word 0x10) follows the pad XOR polarity bit (word 0x20). A clear write has no effect on it while the level persists.
- R5: Single-edge sensing (word 0x24 bit 1, word 0x4C bit 0): polarity 0 latches status on a rising pad transition and polarity 1 on a falling one. The opposite transition does nothing and the bit stays set.
- R6: With both-edge bit 1 in edge mode, rising and falling transitions each set status.
- R7: Writing 1 to a bit of word 0x14 clears that latched edge status bit. Writing 0 leaves it unchanged. Word 0x14 reads zero.
- R8: When an edge detection and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R9: A write to word 0x1C enables each line whose data bit is 1. A write to word 0x18 disables each line whose data bit is 0 and leaves the others alone. A read of word 0x18 returns the enables (1 = enabled).
- R10: `irq` is high exactly when some status bit and its enable are both 1.
- R11: A line with mode bit 0 never holds a status bit, so it never raises `irq`, whatever its pad does.
- R12: The filter-enable word 0x28 stores and reads back its value and has no other effect.
- R13: Each accepted read produces `rsp_valid` high on the following cycle together with its data. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset of the register word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_LINES | Pad input levels |
| pad_out | output | NUM_LINES | Pad output levels |
| pad_oe | output | NUM_LINES | Pad output enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The edge latch and the write-one-to-clear path can act on the same status bit on the same clock edge. The bench places a rising pad transition so that the synchronised edge reaches the status flop on exactly the edge that accepts a clear write for that line. The status bit must read set afterwards, and a later clear alone must then remove it. The level path is judged the same way: a clear written while the active level holds must leave the bit set.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
   localparam int ADDR_W = 7;
   localparam int WORD_W = 32;
   // Register word offsets (software decodes these)
   localparam logic [ADDR_W-1:0] OFF_MODE   = 7'h00;
   localparam logic [ADDR_W-1:0] OFF_DIR    = 7'h04;
   localparam logic [ADDR_W-1:0] OFF_OUT    = 7'h08;
   localparam logic [ADDR_W-1:0] OFF_IN     = 7'h0C;
   localparam logic [ADDR_W-1:0] OFF_STAT   = 7'h10;
   localparam logic [ADDR_W-1:0] OFF_CLR    = 7'h14;
   localparam logic [ADDR_W-1:0] OFF_MASK   = 7'h18;
   localparam logic [ADDR_W-1:0] OFF_UNMASK = 7'h1C;
   localparam logic [ADDR_W-1:0] OFF_POL    = 7'h20;
   localparam logic [ADDR_W-1:0] OFF_EDGE   = 7'h24;
   localparam logic [ADDR_W-1:0] OFF_FILT   = 7'h28;
   localparam logic [ADDR_W-1:0] OFF_BOTH   = 7'h4C;
endpackage

// File: rtl/pbank_sync.sv
module pbank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= '0;
      else        q_prev <= stage[STAGES-1];
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/pbank_sense.sv
module pbank_sense #(
   parameter int W             = 32,
   parameter bit HAS_BOTH_EDGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] mode,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] edge_sel,
   input  logic [W-1:0] both,
   input  logic [W-1:0] clr,
   output logic [W-1:0] status
);
   logic [W-1:0] both_eff;

   if (HAS_BOTH_EDGE) begin : g_both
      assign both_eff = both;
   end else begin : g_single
      logic [W-1:0] unused_both;
      assign unused_both = both;
      assign both_eff    = '0;
   end

   for (genvar g = 0; g < W; g++) begin : g_line
      logic rise, fall, hit, st;
      assign rise = cur[g] & ~prev[g];
      assign fall = ~cur[g] & prev[g];
      assign hit  = both_eff[g] ? (rise | fall) : (pol[g] ? fall : rise);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           st <= 1'b0;
         else if (!mode[g])    st <= 1'b0;
         else if (!edge_sel[g]) st <= cur[g] ^ pol[g];
         else                  st <= hit | (st & ~clr[g]);
      end
      assign status[g] = st;
   end
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
   import pbank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   input  logic [W-1:0]      sync_in,
   input  logic [W-1:0]      status,
   output logic [W-1:0]      mode_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      out_q,
   output logic [W-1:0]      mask_q,
   output logic [W-1:0]      pol_q,
   output logic [W-1:0]      edge_q,
   output logic [W-1:0]      both_q,
   output logic [W-1:0]      clr_pulse,
   output logic [W-1:0]      oe
);
   logic [W-1:0]      filt_q;
   logic [W-1:0]      wd;
   logic [W-1:0]      in_view;
   logic [W-1:0]      rd_line;
   logic [WORD_W-1:0] rd_word;
   logic              wr_en;
   logic              rd_en;

   assign wd        = req_wdata[W-1:0];
   assign wr_en     = req_valid && req_write;
   assign rd_en     = req_valid && !req_write;
   assign clr_pulse = (wr_en && req_addr == OFF_CLR) ? wd : '0;
   assign oe        = dir_q & ~mode_q;
   assign in_view   = (oe & out_q) | (~oe & sync_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0; dir_q  <= '0; out_q  <= '0; mask_q <= '0;
         pol_q  <= '0; edge_q <= '0; both_q <= '0; filt_q <= '0;
      end else if (wr_en) begin
         case (req_addr)
            OFF_MODE:   mode_q <= wd;
            OFF_DIR:    dir_q  <= wd;
            OFF_OUT:    out_q  <= wd;
            OFF_MASK:   mask_q <= mask_q & wd;
            OFF_UNMASK: mask_q <= mask_q | wd;
            OFF_POL:    pol_q  <= wd;
            OFF_EDGE:   edge_q <= wd;
            OFF_FILT:   filt_q <= wd;
            OFF_BOTH:   both_q <= wd;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (req_addr)
         OFF_MODE: rd_line = mode_q;
         OFF_DIR:  rd_line = dir_q;
         OFF_OUT:  rd_line = out_q;
         OFF_IN:   rd_line = in_view;
         OFF_STAT: rd_line = status;
         OFF_MASK: rd_line = mask_q;
         OFF_POL:  rd_line = pol_q;
         OFF_EDGE: rd_line = edge_q;
         OFF_FILT: rd_line = filt_q;
         OFF_BOTH: rd_line = both_q;
         default:  rd_line = '0;
      endcase
      rd_word        = '0;
      rd_word[W-1:0] = rd_line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_en;
         if (rd_en) rsp_rdata <= rd_word;
      end
   end
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
   import pbank_pkg::*;
#(
   parameter int NUM_LINES     = 32,
   parameter int SYNC_STAGES   = 2,
   parameter bit HAS_BOTH_EDGE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [WORD_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic [WORD_W-1:0]    rsp_rdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe,
   output logic                 irq
);
   if (NUM_LINES < 1 || NUM_LINES > WORD_W) begin : g_bad_lines
      $error("pin_bank_irq: NUM_LINES must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_bank_irq: SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] sync_q, sync_prev;
   logic [NUM_LINES-1:0] mode_q, dir_q, out_q, mask_q;
   logic [NUM_LINES-1:0] pol_q, edge_q, both_q, clr_pulse;
   logic [NUM_LINES-1:0] status_q;

   assign req_ready = 1'b1;

   pbank_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q), .q_prev(sync_prev)
   );

   pbank_regs #(.W(NUM_LINES)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sync_in(sync_q), .status(status_q),
      .mode_q(mode_q), .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q),
      .pol_q(pol_q), .edge_q(edge_q), .both_q(both_q),
      .clr_pulse(clr_pulse), .oe(pad_oe)
   );

   pbank_sense #(.W(NUM_LINES), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)) u_sense (
      .clk(clk), .rst_n(rst_n),
      .cur(sync_q), .prev(sync_prev),
      .mode(mode_q), .pol(pol_q), .edge_sel(edge_q), .both(both_q),
      .clr(clr_pulse), .status(status_q)
   );

   assign pad_out = out_q;
   assign irq     = |(status_q & mask_q);
endmodule

// File: rtl/pbank_chk.sv
module pbank_chk #(
   parameter int N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic         req_write,
   input logic [6:0]   req_addr,
   input logic [31:0]  req_wdata,
   input logic         rsp_valid,
   input logic         irq,
   input logic [N-1:0] pad_oe,
   input logic [N-1:0] mode_q,
   input logic [N-1:0] dir_q,
   input logic [N-1:0] edge_q,
   input logic [N-1:0] mask_q,
   input logic [N-1:0] status_q
);
   logic [N-1:0] ck_stat, ck_keep;
   logic         ck_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_stat <= '0; ck_keep <= '0; ck_wr <= 1'b0;
      end else begin
         ck_stat <= status_q;
         ck_keep <= mode_q & edge_q;
         ck_wr   <= req_valid && req_write;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && !irq && mask_q == '0)); // R1

   AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_q) == '0) && ((pad_oe & mode_q) == '0)); // R2

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_wr |-> ((ck_stat & ck_keep & ~status_q) == '0)); // R5

   AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 7'h1C)
      |=> ((mask_q & $past(req_wdata[N-1:0])) == $past(req_wdata[N-1:0]))); // R9

   AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|mask_q && |status_q)); // R10

   AST_PLAIN_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~$past(mode_q)) == '0); // R11

   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid); // R13

   AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid); // R13
endmodule

bind pin_bank_irq pbank_chk #(.N(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .irq(irq), .pad_oe(pad_oe),
   .mode_q(mode_q), .dir_q(dir_q), .edge_q(edge_q),
   .mask_q(mask_q), .status_q(status_q)
);

// File: tb/pin_bank_irq_test.sv
`timescale 1ns/1ps
module pin_bank_irq_test;
   localparam logic [6:0] A_MODE = 7'h00, A_DIR = 7'h04, A_OUT = 7'h08,
                          A_IN = 7'h0C, A_STAT = 7'h10, A_CLR = 7'h14,
                          A_MASK = 7'h18, A_UNMASK = 7'h1C, A_POL = 7'h20,
                          A_EDGE = 7'h24, A_FILT = 7'h28, A_BOTH = 7'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] pads = '0;
   logic        req_ready, rsp_valid, irq;
   logic [31:0] rsp_rdata, pad_out, pad_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [31:0] exp_mask = '0;

   always #2 clk = ~clk;

   pin_bank_irq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pads),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R13 no response to write", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R13 read answered", {31'b0, rsp_valid}, 32'd1);
      d = rsp_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd_chk("R1 mode", A_MODE, 32'h0);
      rd_chk("R1 dir", A_DIR, 32'h0);
      rd_chk("R1 mask", A_MASK, 32'h0);
      rd_chk("R1 status", A_STAT, 32'h0);
      rd_chk("R1 both", A_BOTH, 32'h0);
   endtask

   task automatic t_plain_io;
      logic [31:0] v;
      wr(A_DIR, 32'h0000_00F0);
      wr(A_OUT, 32'h0000_00A0);
      chk("R2 pad_oe", pad_oe, 32'h0000_00F0);
      chk("R2 pad_out", pad_out, 32'h0000_00A0);
      // read accepted on the same edge that first samples the pad: old value
      @(negedge clk);
      pads = 32'h0000_0F5F;
      req_valid = 1'b1; req_write = 1'b0; req_addr = A_IN;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 sync latency", rsp_rdata, 32'h0000_00A0);
      idle(3);
      rd(A_IN, v);
      chk("R3 input view", v, 32'h0000_0FAF);
      wr(A_MODE, 32'h0000_0010);
      chk("R2 interrupt mode drops oe", pad_oe, 32'h0000_00E0);
      wr(A_MODE, 32'h0);
      wr(A_DIR, 32'h0);
      pads = 32'h0;
      idle(4);
   endtask

   task automatic t_level;
      wr(A_EDGE, 32'h0); wr(A_POL, 32'h0);
      wr(A_MODE, 32'h0000_0100);
      wr(A_UNMASK, 32'h0000_0100); exp_mask = 32'h0000_0100;
      pads[8] = 1'b1; idle(4);
      chk("R4 level high irq", {31'b0, irq}, 32'd1);
      rd_chk("R4 level status", A_STAT, 32'h0000_0100);
      wr(A_CLR, 32'h0000_0100);
      rd_chk("R4 clear while level holds", A_STAT, 32'h0000_0100);
      pads[8] = 1'b0; idle(4);
      chk("R10 irq drops with level", {31'b0, irq}, 32'd0);
      rd_chk("R4 level gone", A_STAT, 32'h0);
      wr(A_POL, 32'h0000_0100); idle(3);
      rd_chk("R4 active low", A_STAT, 32'h0000_0100);
      pads[8] = 1'b1; idle(4);
      rd_chk("R4 active low released", A_STAT, 32'h0);
      wr(A_POL, 32'h0); pads[8] = 1'b0;
      wr(A_MODE, 32'h0); idle(4);
   endtask

   task automatic t_edge_single;
      wr(A_EDGE, 32'h0000_0200); wr(A_POL, 32'h0);
      wr(A_MODE, 32'h0000_0200);
      pads[9] = 1'b1; idle(4);
      rd_chk("R5 rising latched", A_STAT, 32'h0000_0200);
      pads[9] = 1'b0; idle(4);
      rd_chk("R5 sticky after fall", A_STAT, 32'h0000_0200);
      wr(A_CLR, 32'h0);
      rd_chk("R7 zero clear no effect", A_STAT, 32'h0000_0200);
      rd_chk("R7 clear word reads zero", A_CLR, 32'h0);
      wr(A_CLR, 32'h0000_0200);
      rd_chk("R7 one clears", A_STAT, 32'h0);
      wr(A_POL, 32'h0000_0200);
      pads[9] = 1'b1; idle(4);
      rd_chk("R5 rising ignored with pol 1", A_STAT, 32'h0);
      pads[9] = 1'b0; idle(4);
      rd_chk("R5 falling latched", A_STAT, 32'h0000_0200);
      wr(A_CLR, 32'h0000_0200); wr(A_POL, 32'h0);
   endtask

   task automatic t_both_edge;
      wr(A_EDGE, 32'h0000_0400); wr(A_BOTH, 32'h0000_0400);
      wr(A_MODE, 32'h0000_0400);
      rd_chk("R11 line left plain mode", A_STAT, 32'h0);
      pads[10] = 1'b1; idle(4);
      rd_chk("R6 rise counted", A_STAT, 32'h0000_0400);
      wr(A_CLR, 32'h0000_0400);
      rd_chk("R6 cleared", A_STAT, 32'h0);
      pads[10] = 1'b0; idle(4);
      rd_chk("R6 fall counted", A_STAT, 32'h0000_0400);
      wr(A_CLR, 32'h0000_0400); wr(A_BOTH, 32'h0);
   endtask

   task automatic t_mask;
      wr(A_EDGE, 32'h0000_0800); wr(A_MODE, 32'h0000_0800);
      pads[11] = 1'b1; idle(4);
      rd_chk("R10 status while disabled", A_STAT, 32'h0000_0800);
      chk("R10 no irq while disabled", {31'b0, irq}, 32'd0);
      wr(A_UNMASK, 32'h0000_0800); exp_mask |= 32'h0000_0800;
      chk("R9 unmask raises irq", {31'b0, irq}, 32'd1);
      rd_chk("R9 mask readback", A_MASK, exp_mask);
      wr(A_MASK, 32'hFFFF_FFFF);
      chk("R9 ones in mask word keep enables", {31'b0, irq}, 32'd1);
      rd_chk("R9 mask unchanged", A_MASK, exp_mask);
      wr(A_MASK, ~32'h0000_0800); exp_mask &= ~32'h0000_0800;
      chk("R9 zero disables", {31'b0, irq}, 32'd0);
      rd_chk("R9 mask after disable", A_MASK, exp_mask);
      wr(A_CLR, 32'h0000_0800);
      pads[11] = 1'b0;
   endtask

   task automatic t_collision;
      wr(A_EDGE, 32'h0000_1000); wr(A_MODE, 32'h0000_1000);
      idle(4);
      @(negedge clk);
      pads[12] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = A_CLR;
      req_wdata = 32'h0000_1000;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rd_chk("R8 set wins over same-edge clear", A_STAT, 32'h0000_1000);
      wr(A_CLR, 32'h0000_1000);
      rd_chk("R7 later clear removes it", A_STAT, 32'h0);
      pads[12] = 1'b0;
      wr(A_MODE, 32'h0);
   endtask

   task automatic t_plain_status;
      wr(A_UNMASK, 32'h0000_2000); exp_mask |= 32'h0000_2000;
      pads[13] = 1'b1; idle(4);
      rd_chk("R11 plain line no status", A_STAT, 32'h0);
      chk("R11 plain line no irq", {31'b0, irq}, 32'd0);
      pads[13] = 1'b0; idle(4);
      rd_chk("R11 plain line after fall", A_STAT, 32'h0);
   endtask

   task automatic t_filter;
      wr(A_FILT, 32'h1234_5678);
      rd_chk("R12 filter readback", A_FILT, 32'h1234_5678);
      rd_chk("R12 no effect on status", A_STAT, 32'h0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_plain_io();
      t_level();
      t_edge_single();
      t_both_edge();
      t_mask();
      t_collision();
      t_plain_status();
      t_filter();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end
endmodule